// File: doc/BRIEF.md
# Compensation Node Current Mode Selector

This block chooses, on every clock, which current source drives the compensation node of a slow voltage-loop error amplifier. The choices are the plain transconductance output, a small fixed source (30 µA class) used for a gentle ramp after start-up, a larger source (100 µA class) that pulls the node up after a sudden output sag, and a 100 µA sink used for overvoltage and for protection states. Its inputs are the digitized feedback voltage, the digitized compensation-node voltage, a run command from the supervisor and a protection flag. The output is a one-hot set of four enables that switch the analog current sources.

The fast source cannot fire just because the feedback is low. It must first be armed by the feedback climbing near regulation. A later sag below a lower threshold then starts it, and the same event uses up the arming. The fast source stays on until the compensation node has climbed to its target code. The sink turns on at an upper feedback threshold and has hysteresis: it releases only once the feedback is back at or below a slightly lower release code. All thresholds are parameters, in 8-bit codes with a 5 V full scale.

Control pins are plain levels. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `comp_drive_sel`

## Requirements
- R1: Exactly one of the four enables is high in every cycle, including in reset. The bit order of the 4-bit enable set is normal=bit0, slow source=bit1, fast source=bit2, sink=bit3.
- R2: In the cycle after run is low with protection low, the normal enable is active. Run low also clears soft-start progress, arming, the fast-source latch and the sink latch.
- R3: After run goes high, the slow source is enabled until the feedback code first reaches REF_CODE (default 179). After that, soft start does not resume until run has been low.
- R4: A feedback code at or above ARM_CODE (default 174) arms the fast response. Arming is used up when the fast source activates, and it is cleared by run low.
- R5: When armed, a feedback code at or below ACT_CODE (default 164), with the compensation code below DONE_CODE (default 164), turns the fast source on. When not armed, the same feedback has no effect on the enables.
- R6: Once on, the fast source stays on until the compensation code is at or above DONE_CODE.
- R7: A feedback code at or above SOVP_CODE (default 188) turns the sink on. The sink stays on until the feedback code is at or below REL_CODE (default 184).
- R8: With the protection flag high, the sink is enabled whatever the run level.
- R9: The priority order is: protection or overvoltage sink first, then fast source, then slow source, then normal.
- R10: Each enable reflects the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run command from supervisor |
| prot_i | input | 1 | Protection state active |
| fb_code_i | input | 8 | Digitized feedback voltage |
| comp_code_i | input | 8 | Digitized compensation-node voltage |
| en_norm_o | output | 1 | Normal transconductance drive |
| en_src_slow_o | output | 1 | 30 µA source (soft start) |
| en_src_fast_o | output | 1 | 100 µA source (fast response) |
| en_sink_o | output | 1 | 100 µA sink |

## Verification
Overlapping functions are the main concern.

- **Overvoltage and fast response.** An overvoltage can arrive while the fast source is still latched on. The bench provokes this by raising the feedback above SOVP_CODE with the compensation code still low. The sink must win, and the fast source must reappear once the feedback falls to the release code.
- **Protection and soft start.** A protection flag is raised in the middle of soft start. The bench expects the sink for that cycle and the slow source again afterwards.

A scoreboard model derived from the requirements predicts each cycle.

// File: rtl/comp_sel_pkg.sv
package comp_sel_pkg;
  localparam int unsigned MODE_N   = 4;
  localparam int unsigned B_NORM   = 0;
  localparam int unsigned B_SLOW   = 1;
  localparam int unsigned B_FAST   = 2;
  localparam int unsigned B_SINK   = 3;
  typedef logic [MODE_N-1:0] mode_oh_t;
  localparam mode_oh_t M_NORM = mode_oh_t'(1) << B_NORM;
  localparam mode_oh_t M_SLOW = mode_oh_t'(1) << B_SLOW;
  localparam mode_oh_t M_FAST = mode_oh_t'(1) << B_FAST;
  localparam mode_oh_t M_SINK = mode_oh_t'(1) << B_SINK;
endpackage

// File: rtl/comp_sel_softstart.sv
module comp_sel_softstart #(
  parameter int unsigned W        = 8,
  parameter int unsigned REF_CODE = 179
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] fb,
  output logic         ss_next
);
  localparam logic [W-1:0] REF_W = W'(REF_CODE);
  logic done_q, done_n;

  always_comb begin
    if (!run) done_n = 1'b0;
    else      done_n = done_q | (fb >= REF_W);
    ss_next = run & ~done_n;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;

  // R2: soft-start progress forgotten after run low
  p_ss_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done_q);
endmodule

// File: rtl/comp_sel_fastresp.sv
module comp_sel_fastresp #(
  parameter int unsigned W         = 8,
  parameter int unsigned ARM_CODE  = 174,
  parameter int unsigned ACT_CODE  = 164,
  parameter int unsigned DONE_CODE = 164
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] fb,
  input  logic [W-1:0] comp,
  output logic         fast_next
);
  localparam logic [W-1:0] ARM_W  = W'(ARM_CODE);
  localparam logic [W-1:0] ACT_W  = W'(ACT_CODE);
  localparam logic [W-1:0] DONE_W = W'(DONE_CODE);

  logic armed_q, armed_n, on_q, on_n, fire, reached;

  always_comb begin
    reached = (comp >= DONE_W);
    fire    = run & armed_q & (fb <= ACT_W) & ~reached;
    if (!run)            armed_n = 1'b0;
    else if (fire)       armed_n = 1'b0;
    else if (fb >= ARM_W) armed_n = 1'b1;
    else                 armed_n = armed_q;
    if (!run)               on_n = 1'b0;
    else if (on_q & reached) on_n = 1'b0;
    else if (fire)          on_n = 1'b1;
    else                    on_n = on_q;
    fast_next = on_n;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed_q <= 1'b0;
      on_q    <= 1'b0;
    end else begin
      armed_q <= armed_n;
      on_q    <= on_n;
    end

  // R5: fast source only starts from an armed state
  p_fire_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_q) |-> $past(armed_q));
  // R4: run low drops the arming
  p_arm_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !armed_q);
  // R6: fast source released once comp target reached
  p_fast_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && comp >= DONE_W) |=> !on_q);
endmodule

// File: rtl/comp_sel_ovsink.sv
module comp_sel_ovsink #(
  parameter int unsigned W         = 8,
  parameter int unsigned SOVP_CODE = 188,
  parameter int unsigned REL_CODE  = 184
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] fb,
  output logic         sink_next
);
  localparam logic [W-1:0] SET_W = W'(SOVP_CODE);
  localparam logic [W-1:0] REL_W = W'(REL_CODE);
  logic sink_q, sink_n;

  always_comb begin
    if (!run)            sink_n = 1'b0;
    else if (fb >= SET_W) sink_n = 1'b1;
    else if (fb <= REL_W) sink_n = 1'b0;
    else                 sink_n = sink_q;
    sink_next = sink_n;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sink_q <= 1'b0;
    else        sink_q <= sink_n;

  // R7: sink latches at the set threshold
  p_sink_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fb >= SET_W) |=> sink_q);
  // R7: sink holds inside the hysteresis band
  p_sink_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sink_q && fb > REL_W) |=> sink_q);
endmodule

// File: rtl/comp_sel_arb.sv
module comp_sel_arb
  import comp_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     prot,
  input  logic     sink_req,
  input  logic     fast_req,
  input  logic     slow_req,
  output mode_oh_t mode
);
  mode_oh_t mode_n, mode_q;

  always_comb begin
    if (prot)          mode_n = M_SINK;
    else if (!run)     mode_n = M_NORM;
    else if (sink_req) mode_n = M_SINK;
    else if (fast_req) mode_n = M_FAST;
    else if (slow_req) mode_n = M_SLOW;
    else               mode_n = M_NORM;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= M_NORM;
    else        mode_q <= mode_n;

  assign mode = mode_q;

  // R1: one enable at a time
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_q) == 1);
  // R8: protection forces the sink
  p_prot_sink_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prot |=> mode_q[B_SINK]);
  // R2: idle means normal drive
  p_idle_norm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !prot) |=> mode_q[B_NORM]);
  // R9: fast request loses only to the sink
  p_fast_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && fast_req && !sink_req && !prot) |=> mode_q[B_FAST]);
endmodule

// File: rtl/comp_drive_sel.sv
module comp_drive_sel
  import comp_sel_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned REF_CODE  = 179,
  parameter int unsigned ARM_CODE  = 174,
  parameter int unsigned ACT_CODE  = 164,
  parameter int unsigned DONE_CODE = 164,
  parameter int unsigned SOVP_CODE = 188,
  parameter int unsigned REL_CODE  = 184
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         prot_i,
  input  logic [W-1:0] fb_code_i,
  input  logic [W-1:0] comp_code_i,
  output logic         en_norm_o,
  output logic         en_src_slow_o,
  output logic         en_src_fast_o,
  output logic         en_sink_o
);
  logic     ss_next, fast_next, sink_next;
  mode_oh_t mode;

  comp_sel_softstart #(.W(W), .REF_CODE(REF_CODE)) u_ss (
    .clk(clk), .rst_n(rst_n), .run(run_i), .fb(fb_code_i), .ss_next(ss_next));

  comp_sel_fastresp #(.W(W), .ARM_CODE(ARM_CODE), .ACT_CODE(ACT_CODE),
                      .DONE_CODE(DONE_CODE)) u_fast (
    .clk(clk), .rst_n(rst_n), .run(run_i), .fb(fb_code_i),
    .comp(comp_code_i), .fast_next(fast_next));

  comp_sel_ovsink #(.W(W), .SOVP_CODE(SOVP_CODE), .REL_CODE(REL_CODE)) u_ov (
    .clk(clk), .rst_n(rst_n), .run(run_i), .fb(fb_code_i),
    .sink_next(sink_next));

  comp_sel_arb u_arb (
    .clk(clk), .rst_n(rst_n), .run(run_i), .prot(prot_i),
    .sink_req(sink_next), .fast_req(fast_next), .slow_req(ss_next),
    .mode(mode));

  assign en_norm_o     = mode[B_NORM];
  assign en_src_slow_o = mode[B_SLOW];
  assign en_src_fast_o = mode[B_FAST];
  assign en_sink_o     = mode[B_SINK];
endmodule

// File: tb/tb_comp_drive_sel.sv
module tb_comp_drive_sel;
  localparam int REF = 179, ARM = 174, ACT = 164, DONE = 164, SOVP = 188, REL = 184;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, prot = 1'b0;
  logic [7:0] fb = 8'd0, comp = 8'd0;
  logic e_norm, e_slow, e_fast, e_sink;
  int checks = 0, errors = 0;

  typedef struct { logic [3:0] exp; string req; } item_t;
  item_t sbq[$];

  // reference model state, built from the requirement text
  logic m_done = 0, m_arm = 0, m_on = 0, m_sink = 0;

  always #4 clk = ~clk;

  comp_drive_sel dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .prot_i(prot),
    .fb_code_i(fb), .comp_code_i(comp),
    .en_norm_o(e_norm), .en_src_slow_o(e_slow),
    .en_src_fast_o(e_fast), .en_sink_o(e_sink));

  function automatic logic [3:0] outs();
    return {e_sink, e_fast, e_slow, e_norm};
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // driver: apply inputs, step the model, queue the expected enables
  task automatic step(input logic r, input logic p, input int f, input int c, input string req);
    logic fire;
    logic [3:0] e;
    @(negedge clk);
    run = r; prot = p; fb = 8'(f); comp = 8'(c);
    if (!r) begin
      m_done = 0; m_arm = 0; m_on = 0; m_sink = 0;
    end else begin
      fire = m_arm && f <= ACT && c < DONE;
      if (f >= REF) m_done = 1;
      if (m_on && c >= DONE) m_on = 0; else if (fire) m_on = 1;
      if (fire) m_arm = 0; else if (f >= ARM) m_arm = 1;
      if (f >= SOVP) m_sink = 1; else if (f <= REL) m_sink = 0;
    end
    if (p)             e = 4'b1000;
    else if (!r)       e = 4'b0001;
    else if (m_sink)   e = 4'b1000;
    else if (m_on)     e = 4'b0100;
    else if (!m_done)  e = 4'b0010;
    else               e = 4'b0001;
    sbq.push_back('{e, req});
  endtask

  // monitor: sample away from the edge, one cycle after drive (R10)
  initial forever begin
    @(posedge clk);
    #2;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(outs(), it.exp, it.req);
    end
  end

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #10;
    check(outs(), 4'b0001, "R1 reset state normal");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 100, 0,   "R2 idle normal");
    step(1, 0, 50,  0,   "R3 soft start slow source");
    step(1, 0, 164, 100, "R5 low fb unarmed no effect");
    step(1, 0, 178, 100, "R3 slow source below ref");
    step(1, 1, 178, 100, "R8 protection mid soft start");
    step(1, 0, 178, 100, "R9 soft start resumes after prot");
    step(1, 0, 179, 100, "R3 ref reached normal");
    step(1, 0, 170, 100, "R3 no soft start resume");
    step(1, 0, 164, 100, "R5 armed sag fast source");
    step(1, 0, 160, 150, "R6 fast holds");
    step(1, 0, 160, 164, "R6 fast released at done");
    step(1, 0, 160, 100, "R4 arm consumed");
    step(1, 0, 175, 100, "R4 rearm");
    step(1, 0, 164, 100, "R5 fires again");
    step(1, 0, 190, 100, "R9 sink over fast");
    step(1, 0, 186, 100, "R7 sink hold band");
    step(1, 0, 184, 100, "R7 release fast shows");
    step(1, 0, 176, 170, "R6 fast off");
    step(1, 0, 188, 170, "R7 sink at threshold");
    step(1, 0, 185, 170, "R7 sink still held");
    step(1, 0, 180, 170, "R7 sink released");
    step(0, 1, 100, 0,   "R8 prot with run low");
    step(0, 0, 100, 0,   "R2 run low normal");
    step(1, 0, 170, 100, "R2 soft start restarts");
    step(1, 0, 164, 100, "R4 arm cleared by run low");
    step(1, 0, 179, 100, "R3 done again");
    step(1, 0, 187, 100, "R7 below set no sink");
    step(0, 0, 187, 100, "R2 idle normal again");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule